// File: doc/BRIEF.md
# Shared SRAM Port Arbiter with Byte-Lane Read-Modify-Write

This block places one external 16-bit asynchronous SRAM between a display fetch path and a single active drawing engine. It divides the system clock by two to form a pixel clock and opens exactly one memory slot per pixel period. The slot starts on the system-clock edge where the pixel clock rises. The display fetch owns any slot that starts while its active input is high, and the engine then waits. Otherwise the engine's request is served as a read or a write, depending on its write flag.

Engines see the memory as bytes. Each SRAM word holds two 8-bit pixels, and the least significant bit of the engine's byte address picks the half. A byte write is done as a read-modify-write inside one slot. The word is read while the pixel clock is high. It is captured on the following system-clock edge, the new byte is merged into the chosen half, and the whole word is written back while the pixel clock is low. A one-cycle done pulse tells the engine its access has finished. The engine keeps its request, address and data steady until that pulse.

Top module: `sram_share_arb`

## Requirements
- R1: `pix_clk` is 0 after reset and changes value on every system-clock edge, so its rate is half the system clock.
- R2: `sram_addr` changes only on a system-clock edge where `pix_clk` rises, which allows at most one memory access per pixel period.
- R3: When `disp_active` is 1 at a slot's start edge, the slot reads the word at `disp_addr`. The SRAM word is returned on `disp_rdata` with a one-cycle `disp_valid` pulse. `eng_done` is not asserted for that slot, and a pending engine write leaves memory unchanged until a later slot.
- R4: An engine read drives `eng_addr[18:1]` as the word address and returns bits [7:0] of the word when `eng_addr[0]` is 0, or bits [15:8] when it is 1.
- R5: An engine write replaces only the half selected by `eng_addr[0]` (0 = [7:0], 1 = [15:8]) with `eng_wdata`, and keeps the other half. The word is read in the slot's high pixel phase and written back in its low phase.
- R6: Each served engine access gives exactly one `eng_done` pulse, one system-clock cycle wide. `eng_rdata` is valid while the pulse is high.
- R7: `sram_we_n` is low only while `pix_clk` is low, `sram_oe_n` is high and `sram_ce_n` is low. The block drives `sram_dq` only while `sram_we_n` is low, and leaves it high impedance at all other times.
- R8: During and right after reset, `sram_ce_n`, `sram_oe_n`, `sram_we_n` and all `sram_be_n` bits are 1, `eng_done` and `disp_valid` are 0, and `sram_dq` is not driven.
- R9: A slot that starts with neither `disp_active` nor `eng_req` high leaves `sram_ce_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_clk | output | 1 | Pixel clock, system clock divided by two |
| disp_active | input | 1 | Display fetch owns the next slot |
| disp_addr | input | 18 | Display word address |
| disp_rdata | output | 16 | Word returned to the display |
| disp_valid | output | 1 | One-cycle pulse when disp_rdata is updated |
| eng_req | input | 1 | Engine access request, held until eng_done |
| eng_we | input | 1 | 1 = byte write, 0 = byte read |
| eng_addr | input | 19 | Engine byte address |
| eng_wdata | input | 8 | Byte to write |
| eng_rdata | output | 8 | Byte read, valid with eng_done |
| eng_done | output | 1 | One-cycle completion pulse |
| sram_addr | output | 18 | SRAM word address |
| sram_dq | inout | 16 | SRAM data bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_be_n | output | 2 | Byte-lane enables, active low, bit 0 = low byte |

## Verification
If the slot phase or the operation register held a wrong value, the fault would show within one pixel period. `sram_addr` would move on the wrong edge, or the write strobe would fall while `pix_clk` is high. A wrong lane select shows up on the next read-back of the same word: the byte lands in the other half, or the neighbouring pixel is corrupted. A priority fault shows up as an `eng_done` pulse, or as a changed word, while the display is still active.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_DISP = 2'd1,
      OP_RD   = 2'd2,
      OP_WR   = 2'd3
   } slot_op_e;
endpackage

// File: rtl/sram_arb_phase.sv
module sram_arb_phase (
   input  logic clk,
   input  logic rst_n,
   output logic pix_clk,
   output logic slot_start
);
   logic ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ph_q <= 1'b0;
      else        ph_q <= ~ph_q;
   end

   assign pix_clk    = ph_q;
   // the next edge raises the pixel clock and opens a new slot
   assign slot_start = ~ph_q;
endmodule

// File: rtl/sram_arb_lanes.sv
module sram_arb_lanes #(
   parameter int WORD_W = 16,
   parameter int PIX_W  = 8,
   parameter int LSEL   = 1
) (
   input  logic [WORD_W-1:0] word,
   input  logic [LSEL-1:0]   sel,
   input  logic [PIX_W-1:0]  wbyte,
   output logic [PIX_W-1:0]  rbyte,
   output logic [WORD_W-1:0] merged
);
   localparam int LANES = WORD_W / PIX_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*PIX_W +: PIX_W] =
         (sel == LSEL'(l)) ? wbyte : word[l*PIX_W +: PIX_W];
   end

   always_comb begin
      rbyte = '0;
      for (int l = 0; l < LANES; l++) begin
         if (sel == LSEL'(l)) rbyte = word[l*PIX_W +: PIX_W];
      end
   end
endmodule

// File: rtl/sram_share_arb.sv
module sram_share_arb
   import sram_arb_pkg::*;
#(
   parameter  int BYTE_AW = 19,
   parameter  int WORD_W  = 16,
   parameter  int PIX_W   = 8,
   localparam int LANES   = WORD_W / PIX_W,
   localparam int LSEL    = $clog2(LANES),
   localparam int WAW     = BYTE_AW - LSEL
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic               pix_clk,
   input  logic               disp_active,
   input  logic [WAW-1:0]     disp_addr,
   output logic [WORD_W-1:0]  disp_rdata,
   output logic               disp_valid,
   input  logic               eng_req,
   input  logic               eng_we,
   input  logic [BYTE_AW-1:0] eng_addr,
   input  logic [PIX_W-1:0]   eng_wdata,
   output logic [PIX_W-1:0]   eng_rdata,
   output logic               eng_done,
   output logic [WAW-1:0]     sram_addr,
   inout  wire  [WORD_W-1:0]  sram_dq,
   output logic               sram_ce_n,
   output logic               sram_oe_n,
   output logic               sram_we_n,
   output logic [LANES-1:0]   sram_be_n
);
   initial begin
      assert (WORD_W % PIX_W == 0)
         else $error("WORD_W must be a whole number of pixels");
      assert (LANES >= 2 && (LANES & (LANES - 1)) == 0)
         else $error("pixels per word must be a power of two, at least 2");
      assert (BYTE_AW > LSEL)
         else $error("BYTE_AW too narrow for lane select");
   end

   logic slot_start;

   sram_arb_phase u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .pix_clk    (pix_clk),
      .slot_start (slot_start)
   );

   slot_op_e          op_q;
   logic [WAW-1:0]    addr_q;
   logic [LSEL-1:0]   sel_q;
   logic [PIX_W-1:0]  wbyte_q;
   logic [WORD_W-1:0] wword_q;
   logic              drv_q;
   logic              ce_n_q, oe_n_q, we_n_q;
   logic [LANES-1:0]  be_n_q;
   logic              done_q, valid_q;
   logic [PIX_W-1:0]  rdata_q;
   logic [WORD_W-1:0] drdata_q;
   logic [PIX_W-1:0]  lane_rbyte;
   logic [WORD_W-1:0] lane_merged;

   sram_arb_lanes #(
      .WORD_W (WORD_W),
      .PIX_W  (PIX_W),
      .LSEL   (LSEL)
   ) u_lanes (
      .word   (sram_dq),
      .sel    (sel_q),
      .wbyte  (wbyte_q),
      .rbyte  (lane_rbyte),
      .merged (lane_merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q     <= OP_IDLE;
         addr_q   <= '0;
         sel_q    <= '0;
         wbyte_q  <= '0;
         wword_q  <= '0;
         drv_q    <= 1'b0;
         ce_n_q   <= 1'b1;
         oe_n_q   <= 1'b1;
         we_n_q   <= 1'b1;
         be_n_q   <= '1;
         done_q   <= 1'b0;
         valid_q  <= 1'b0;
         rdata_q  <= '0;
         drdata_q <= '0;
      end else begin
         done_q  <= 1'b0;
         valid_q <= 1'b0;
         if (slot_start) begin
            // rising pixel edge: close the previous write, open one access
            we_n_q <= 1'b1;
            drv_q  <= 1'b0;
            if (disp_active) begin
               op_q   <= OP_DISP;
               addr_q <= disp_addr;
               ce_n_q <= 1'b0;
               oe_n_q <= 1'b0;
               be_n_q <= '0;
            end else if (eng_req) begin
               op_q    <= eng_we ? OP_WR : OP_RD;
               addr_q  <= eng_addr[BYTE_AW-1:LSEL];
               sel_q   <= eng_addr[LSEL-1:0];
               wbyte_q <= eng_wdata;
               ce_n_q  <= 1'b0;
               oe_n_q  <= 1'b0;
               be_n_q  <= '0;
            end else begin
               op_q   <= OP_IDLE;
               ce_n_q <= 1'b1;
               oe_n_q <= 1'b1;
               be_n_q <= '1;
            end
         end else begin
            // low pixel phase: capture read word, maybe write back
            unique case (op_q)
               OP_DISP: begin
                  drdata_q <= sram_dq;
                  valid_q  <= 1'b1;
                  ce_n_q   <= 1'b1;
                  oe_n_q   <= 1'b1;
                  be_n_q   <= '1;
               end
               OP_RD: begin
                  rdata_q <= lane_rbyte;
                  done_q  <= 1'b1;
                  ce_n_q  <= 1'b1;
                  oe_n_q  <= 1'b1;
                  be_n_q  <= '1;
               end
               OP_WR: begin
                  wword_q <= lane_merged;
                  drv_q   <= 1'b1;
                  oe_n_q  <= 1'b1;
                  we_n_q  <= 1'b0;
                  done_q  <= 1'b1;
               end
               default: ;
            endcase
            op_q <= OP_IDLE;
         end
      end
   end

   assign sram_dq    = drv_q ? wword_q : {WORD_W{1'bz}};
   assign sram_addr  = addr_q;
   assign sram_ce_n  = ce_n_q;
   assign sram_oe_n  = oe_n_q;
   assign sram_we_n  = we_n_q;
   assign sram_be_n  = be_n_q;
   assign eng_done   = done_q;
   assign eng_rdata  = rdata_q;
   assign disp_valid = valid_q;
   assign disp_rdata = drdata_q;

   a_r2_one_access_per_pixel: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(pix_clk) |-> $stable(sram_addr));

   a_r3_display_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pix_clk) && $past(disp_active)) |=> !eng_done);

   a_r5_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> $past(!sram_oe_n));

   a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> !eng_done);

   a_r7_strobe_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (!pix_clk && sram_oe_n && !sram_ce_n));

   a_r9_idle_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pix_clk) && !$past(disp_active) && !$past(eng_req)) |-> sram_ce_n);
endmodule

// File: tb/sram_share_arb_bench.sv
`timescale 1ns/1ps
module sram_share_arb_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_clk;
   logic        disp_active = 1'b0;
   logic [17:0] disp_addr = '0;
   logic [15:0] disp_rdata;
   logic        disp_valid;
   logic        eng_req = 1'b0;
   logic        eng_we = 1'b0;
   logic [18:0] eng_addr = '0;
   logic [7:0]  eng_wdata = '0;
   logic [7:0]  eng_rdata;
   logic        eng_done;
   logic [17:0] sram_addr;
   wire  [15:0] sram_dq;
   logic        sram_ce_n, sram_oe_n, sram_we_n;
   logic [1:0]  sram_be_n;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int r2_bad = 0;
   int r7_bad = 0;

   always #2.5 clk = ~clk;

   sram_share_arb u_sram_share_arb (
      .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk),
      .disp_active(disp_active), .disp_addr(disp_addr),
      .disp_rdata(disp_rdata), .disp_valid(disp_valid),
      .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
      .eng_wdata(eng_wdata), .eng_rdata(eng_rdata), .eng_done(eng_done),
      .sram_addr(sram_addr), .sram_dq(sram_dq), .sram_ce_n(sram_ce_n),
      .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_be_n(sram_be_n)
   );

   // small asynchronous SRAM model, 64 words
   logic [15:0] mem [64];
   logic [15:0] exp_mem [64];

   function automatic logic [15:0] pat(int i);
      return {8'(i) + 8'h40, 8'(i) ^ 8'hC3};
   endfunction

   assign sram_dq = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr[5:0]] : 16'hzzzz;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= pat(i);
      end else if (!sram_ce_n && !sram_we_n) begin
         mem[sram_addr[5:0]] <= sram_dq;
      end
   end

   // bus and address monitors (R2, R7)
   logic [17:0] last_addr;
   logic        mon_on = 1'b0;
   always @(negedge clk) begin
      if (mon_on) begin
         if (sram_addr !== last_addr && pix_clk !== 1'b1) r2_bad++;
         if (!sram_we_n && pix_clk) r7_bad++;
         if (sram_we_n && sram_oe_n && sram_dq !== 16'hzzzz) r7_bad++;
      end
      last_addr = sram_addr;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=%0d cycles expected=<50000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic eng_access(input logic we, input logic [18:0] ba,
                             input logic [7:0] wd, output logic [7:0] rd);
      int waited;
      @(negedge clk);
      eng_req = 1'b1; eng_we = we; eng_addr = ba; eng_wdata = wd;
      waited = 0;
      do begin
         @(negedge clk);
         waited++;
      end while (!eng_done && waited < 40);
      chk("R6 done seen", {31'b0, eng_done}, 32'd1);
      rd = eng_rdata;
      eng_req = 1'b0;
      @(negedge clk);
      chk("R6 done width", {31'b0, eng_done}, 32'd0);
   endtask

   task automatic disp_read(input logic [17:0] wa, output logic [15:0] wd);
      int waited;
      @(negedge clk);
      disp_active = 1'b1; disp_addr = wa;
      waited = 0;
      do begin
         @(negedge clk);
         waited++;
      end while (!disp_valid && waited < 20);
      chk("R3 display valid", {31'b0, disp_valid}, 32'd1);
      wd = disp_rdata;
      disp_active = 1'b0;
      @(negedge clk);
      chk("R3 valid width", {31'b0, disp_valid}, 32'd0);
   endtask

   task automatic t_reset_r8;
      @(negedge clk);
      chk("R8 ce_n", {31'b0, sram_ce_n}, 32'd1);
      chk("R8 oe_n", {31'b0, sram_oe_n}, 32'd1);
      chk("R8 we_n", {31'b0, sram_we_n}, 32'd1);
      chk("R8 be_n", {30'b0, sram_be_n}, 32'd3);
      chk("R8 done/valid", {30'b0, eng_done, disp_valid}, 32'd0);
      chk("R8 bus", {16'h0, sram_dq}, {16'h0, 16'hzzzz});
   endtask

   task automatic t_pixclk_r1;
      logic prev;
      int bad = 0;
      @(negedge clk);
      prev = pix_clk;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (pix_clk === prev) bad++;
         prev = pix_clk;
      end
      chk("R1 pix_clk toggles", bad, 0);
   endtask

   task automatic t_idle_r9;
      int bad = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (sram_ce_n !== 1'b1) bad++;
      end
      chk("R9 idle ce_n high", bad, 0);
   endtask

   task automatic t_read_r4;
      logic [7:0] rd;
      eng_access(1'b0, {18'd5, 1'b0}, 8'h00, rd);
      chk("R4 low byte w5", {24'b0, rd}, {24'b0, exp_mem[5][7:0]});
      eng_access(1'b0, {18'd5, 1'b1}, 8'h00, rd);
      chk("R4 high byte w5", {24'b0, rd}, {24'b0, exp_mem[5][15:8]});
      eng_access(1'b0, {18'd37, 1'b1}, 8'h00, rd);
      chk("R4 high byte w37", {24'b0, rd}, {24'b0, exp_mem[37][15:8]});
   endtask

   task automatic t_write_r5;
      logic [7:0] rd;
      logic [15:0] wd;
      eng_access(1'b1, {18'd9, 1'b1}, 8'h3C, rd);
      exp_mem[9][15:8] = 8'h3C;
      eng_access(1'b0, {18'd9, 1'b1}, 8'h00, rd);
      chk("R5 high written", {24'b0, rd}, {24'b0, exp_mem[9][15:8]});
      eng_access(1'b0, {18'd9, 1'b0}, 8'h00, rd);
      chk("R5 low kept", {24'b0, rd}, {24'b0, exp_mem[9][7:0]});
      eng_access(1'b1, {18'd20, 1'b0}, 8'hA7, rd);
      exp_mem[20][7:0] = 8'hA7;
      disp_read(18'd20, wd);
      chk("R5 word after low write", {16'b0, wd}, {16'b0, exp_mem[20]});
   endtask

   task automatic t_priority_r3;
      int dones = 0;
      int valids = 0;
      int waited;
      logic [15:0] wd;
      @(negedge clk);
      disp_active = 1'b1; disp_addr = 18'd12;
      eng_req = 1'b1; eng_we = 1'b1; eng_addr = {18'd12, 1'b0}; eng_wdata = 8'hEE;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (eng_done) dones++;
         if (disp_valid) valids++;
      end
      chk("R3 engine stalled", dones, 0);
      chk("R3 display served", valids, 6);
      chk("R3 word unchanged", {16'b0, disp_rdata}, {16'b0, exp_mem[12]});
      disp_active = 1'b0;
      waited = 0;
      do begin
         @(negedge clk);
         waited++;
      end while (!eng_done && waited < 10);
      chk("R3 engine served after", {31'b0, eng_done}, 32'd1);
      eng_req = 1'b0;
      exp_mem[12][7:0] = 8'hEE;
      disp_read(18'd12, wd);
      chk("R3 word updated later", {16'b0, wd}, {16'b0, exp_mem[12]});
   endtask

   initial begin
      for (int i = 0; i < 64; i++) exp_mem[i] = pat(i);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset_r8();
      mon_on = 1'b1;
      t_pixclk_r1();
      t_idle_r9();
      t_read_r4();
      t_write_r5();
      t_priority_r3();
      repeat (4) @(negedge clk);
      chk("R2 address moves only on pixel rise", r2_bad, 0);
      chk("R7 strobe and bus discipline", r7_bad, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule